// File: doc/BRIEF.md
# Single-Bus Register Swap Controller

The block holds two data registers, A and B, and a scratch register T. All three share one data bus, so only one value can move in any clock cycle. A two-bit Moore state machine exchanges the contents of A and B in three transfer steps, routing the value through T. In each step the machine picks the register that drives the bus and enables the load of one destination register.

A swap begins when `start` is seen high in the idle state. `done` is high for one cycle during the last transfer, and the machine then returns to idle. A preset port writes A and B while the machine is idle, so the block can be given known contents for testing.

Top module: `regswap`

## Requirements
- R1: While `rst` is high at a rising edge, the machine goes to idle and A, B and T are cleared to zero. After reset `done` is 0, `load_en` is 3'b000 and `bus_sel` is 0.
- R2: In idle with `start` low, the state does not change, `load_en` stays 3'b000, and T keeps its value.
- R3: In idle, a rising edge with `pre_ld` high writes `pre_a` into A and `pre_b` into B.
- R4: `pre_ld` has no effect outside the idle state.
- R5: After `start` is seen high in idle, the next three cycles are fixed. Cycle 1 has `bus_sel`=1 (B drives the bus) and `load_en`=3'b100 (T loads). Cycle 2 has `bus_sel`=0 (A drives) and `load_en`=3'b010 (B loads). Cycle 3 has `bus_sel`=2 (T drives) and `load_en`=3'b001 (A loads). In `load_en`, bit 0 is A, bit 1 is B and bit 2 is T.
- R6: At most one bit of `load_en` is high in any cycle.
- R7: When a swap completes, A holds the old B, B holds the old A, and T holds the old B.
- R8: `done` is high only in the third transfer cycle and for exactly one cycle per swap. The machine is idle in the next cycle, whatever the level of `start`.
- R9: If `start` stays high, a second swap begins in the cycle after the return to idle. It restores the original values of A and B and leaves the old A in T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a swap when high in idle |
| pre_ld | input | 1 | Preset strobe for A and B, acts only in idle |
| pre_a | input | W | Preset value for A |
| pre_b | input | W | Preset value for B |
| reg_a | output | W | Contents of A |
| reg_b | output | W | Contents of B |
| reg_t | output | W | Contents of T |
| bus_sel | output | 2 | Bus source: 0 = A, 1 = B, 2 = T |
| load_en | output | 3 | Load enables: bit 0 = A, bit 1 = B, bit 2 = T |
| done | output | 1 | High in the final transfer cycle |

## Verification
The assertions check on every cycle that:
- at most one load enable is high;
- the three transfer steps follow each other in order;
- a start in idle always enters the first step;
- `done` never lasts more than one cycle;
- each enabled load captures the value of the register that drives the bus.

Only the bench scenarios can show the following:
- A and B actually end up exchanged;
- preset data is taken in idle and ignored during a swap;
- a held `start` chains a second swap that restores the original values.

The bench queues the expected final contents for each swap and compares them when `done` falls.

// File: rtl/regswap.sv
module regswap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         pre_ld,
  input  logic [W-1:0] pre_a,
  input  logic [W-1:0] pre_b,
  output logic [W-1:0] reg_a,
  output logic [W-1:0] reg_b,
  output logic [W-1:0] reg_t,
  output logic [1:0]   bus_sel,
  output logic [2:0]   load_en,
  output logic         done
);
  logic [1:0]   st, st_nx;
  logic [W-1:0] bus;
  logic         idle;

  assign idle     = (st == 2'b00);
  assign st_nx[1] = st[1] ^ st[0];
  assign st_nx[0] = (start & ~st[1] & ~st[0]) | (st[1] & ~st[0]);

  assign bus_sel = (st == 2'b01) ? 2'd1 :
                   (st == 2'b11) ? 2'd2 : 2'd0;
  assign load_en = {st == 2'b01, st == 2'b10, st == 2'b11};
  assign done    = (st == 2'b11);

  always_comb begin
    case (bus_sel)
      2'd1:    bus = reg_b;
      2'd2:    bus = reg_t;
      default: bus = reg_a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= 2'b00;
      reg_a <= '0;
      reg_b <= '0;
      reg_t <= '0;
    end else begin
      st <= st_nx;
      if (idle && pre_ld) begin
        reg_a <= pre_a;
        reg_b <= pre_b;
      end else begin
        if (load_en[0]) reg_a <= bus;
        if (load_en[1]) reg_b <= bus;
      end
      if (load_en[2]) reg_t <= bus;
    end
  end
endmodule

module regswap_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] reg_a,
  input logic [W-1:0] reg_b,
  input logic [W-1:0] reg_t,
  input logic [2:0]   load_en,
  input logic         done
);
  AST_ONE_LOAD:   assert property (@(posedge clk) disable iff (rst) $onehot0(load_en)); // R6
  AST_STEP_1_2:   assert property (@(posedge clk) disable iff (rst) load_en == 3'b100 |=> load_en == 3'b010); // R5
  AST_STEP_2_3:   assert property (@(posedge clk) disable iff (rst) load_en == 3'b010 |=> load_en == 3'b001); // R5
  AST_STEP_3_IDLE: assert property (@(posedge clk) disable iff (rst) load_en == 3'b001 |=> load_en == 3'b000); // R8
  AST_START_GO:   assert property (@(posedge clk) disable iff (rst) (load_en == 3'b000 && start) |=> load_en == 3'b100); // R5
  AST_IDLE_WAIT:  assert property (@(posedge clk) disable iff (rst) (load_en == 3'b000 && !start) |=> (load_en == 3'b000 && $stable(reg_t))); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
  AST_T_CAPTURE:  assert property (@(posedge clk) disable iff (rst) load_en[2] |=> reg_t == $past(reg_b)); // R7
  AST_B_CAPTURE:  assert property (@(posedge clk) disable iff (rst) load_en[1] |=> reg_b == $past(reg_a)); // R7
  AST_A_CAPTURE:  assert property (@(posedge clk) disable iff (rst) load_en[0] |=> reg_a == $past(reg_t)); // R7
endmodule

bind regswap regswap_chk #(.W(W)) u_chk (.*);

// File: tb/test_regswap.sv
`timescale 1ns/1ps
module test_regswap;
  localparam int W = 8;
  logic clk = 0, rst = 1, start = 0, pre_ld = 0;
  logic [W-1:0] pre_a = 0, pre_b = 0;
  logic [W-1:0] reg_a, reg_b, reg_t;
  logic [1:0] bus_sel;
  logic [2:0] load_en;
  logic done;
  int n_chk = 0, n_bad = 0;
  logic [3*W-1:0] sb_q[$];
  logic prev_done = 0;

  always #2.5 clk = ~clk;

  regswap #(.W(W)) i_regswap (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (prev_done && !done) begin
      logic [3*W-1:0] e;
      if (sb_q.size() == 0) chk(0, "R7 unexpected completion", 0, 0);
      else begin
        e = sb_q.pop_front();
        chk(reg_a == e[3*W-1:2*W], "R7 A after swap", reg_a, e[3*W-1:2*W]);
        chk(reg_b == e[2*W-1:W],   "R7 B after swap", reg_b, e[2*W-1:W]);
        chk(reg_t == e[W-1:0],     "R7 T after swap", reg_t, e[W-1:0]);
      end
    end
    prev_done = done;
  end

  task automatic swap(input logic [W-1:0] a, input logic [W-1:0] b, input bit hold);
    @(negedge clk); pre_ld = 1; pre_a = a; pre_b = b;
    @(negedge clk);
    chk(reg_a == a && reg_b == b, "R3 preset in idle", {reg_a, reg_b}, {a, b});
    sb_q.push_back({b, a, b});
    pre_ld = 0; start = 1;
    @(negedge clk); start = hold;
    pre_ld = 1; pre_a = ~a; pre_b = ~b;
    chk(load_en == 3'b100 && bus_sel == 2'd1, "R5 step 1", {bus_sel, load_en}, {2'd1, 3'b100});
    @(negedge clk);
    chk(load_en == 3'b010 && bus_sel == 2'd0, "R5 step 2", {bus_sel, load_en}, {2'd0, 3'b010});
    chk(done == 0, "R8 done low in step 2", done, 0);
    @(negedge clk);
    chk(load_en == 3'b001 && bus_sel == 2'd2, "R5 step 3", {bus_sel, load_en}, {2'd2, 3'b001});
    chk(done == 1, "R8 done in step 3", done, 1);
    @(negedge clk); pre_ld = 0;
    chk(load_en == 3'b000 && done == 0, "R8 idle after step 3", {done, load_en}, 0);
    chk(reg_a == b && reg_b == a, "R4 preset ignored while busy", {reg_a, reg_b}, {b, a});
    if (hold) begin
      sb_q.push_back({a, b, a});
      @(negedge clk); start = 0;
      chk(load_en == 3'b100, "R9 second swap starts", load_en, 3'b100);
      repeat (3) @(negedge clk);
      chk(reg_a == a && reg_b == b && reg_t == a, "R9 values restored",
          {reg_a, reg_b, reg_t}, {a, b, a});
    end
  endtask

  initial begin
    #20000;
    chk(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(reg_a == 0 && reg_b == 0 && reg_t == 0, "R1 regs cleared", {reg_a, reg_b, reg_t}, 0);
    chk(done == 0 && load_en == 0 && bus_sel == 0, "R1 controls idle", {done, bus_sel, load_en}, 0);
    rst = 0;
    swap(8'h3C, 8'hA5, 0);
    repeat (4) @(negedge clk);
    chk(load_en == 0, "R2 stays idle without start", load_en, 0);
    chk(reg_t == 8'hA5 && reg_a == 8'hA5, "R2 registers held", {reg_a, reg_t}, {8'hA5, 8'hA5});
    swap(8'h00, 8'hFF, 0);
    swap(8'h81, 8'h7E, 1);
    swap(8'h55, 8'h55, 0);
    repeat (2) @(negedge clk);
    chk(sb_q.size() == 0, "R7 all swaps completed", sb_q.size(), 0);
    rst = 1;
    @(negedge clk); rst = 0;
    chk(reg_a == 0 && reg_b == 0 && reg_t == 0 && load_en == 0, "R1 reset again",
        {reg_a, reg_b, reg_t}, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule